// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the target-side transaction layer of an SMBus port. It sits above a byte-level bus engine that handles bit timing and reports single-cycle events: a START (also used for a repeated START), a STOP, each byte received from the master, each request for the next byte to transmit, and the master's ACK or NACK on every byte the target has sent. The responder answers each received byte with an ACK decision and each transmit request with a data byte. It also tells the engine when it owns the data line for reading.

Inside is a small register file addressed by a register pointer. The first byte of a write selects the pointer, and any further bytes are stored from there with auto-increment. Reads return bytes from the pointer onward, low byte before high byte for words. The pointer survives STOP, so a bare read with no command byte returns the last selected register. Registers flagged as block registers hold a length. A write to one stores a clamped count and then accepts that many bytes. A read of one returns the count first and then the bytes. Packet error checking, address resolution, alerts and bit timing are handled elsewhere.

Top module: `smbus_target_resp`

## Requirements
- R1: The first byte after a START holds the target address in bits 7:1 and the direction in bit 0. It is ACKed only when bits 7:1 equal OWN_ADDR. When bit 0 is 1 and the address matches, tx_en rises in the same cycle as that ACK.
- R2: In a write transaction the byte after the address is the command. Its low log2(NREG) bits become the register pointer. Every later byte is ACKed and stored at the pointer.
- R3: After a write of only a command byte, a read (after a repeated START or in a new transaction) returns the register it selected. A read transaction with no command byte returns the register at the current pointer.
- R4: The pointer increments after each data byte written or transmitted and wraps from NREG-1 to 0. A word is the byte at the pointer (low) followed by the byte at pointer+1 (high).
- R5: When the master NACKs a transmitted byte, tx_en is low on the next cycle. Until the next START, transmit requests return 0xFF and do not move the pointer.
- R6: A read whose first byte comes from a block register first sends min(stored value, 32) as a count. It then sends that many bytes from the following registers. Further requests return 0xFF.
- R7: In a write to a block register, the byte after the command is a count, stored as min(count, 32). Only that many following data bytes are ACKed and stored. Extra bytes are NACKed and not stored.
- R8: After a STOP, tx_en is low, received bytes are NACKed and not stored, and transmit requests return 0xFF until the next START.
- R9: After an address byte that does not match, every byte up to the next START is NACKed and nothing is stored.
- R10: After reset, register i holds (7*i+3) mod 256, the pointer is 0, and rsp_ack_valid, tx_valid and tx_en are low.
- R11: rsp_ack_valid pulses exactly one cycle after each rx_valid. tx_valid pulses exactly one cycle after each tx_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | START or repeated START seen (one-cycle pulse) |
| bus_stop | input | 1 | STOP seen (one-cycle pulse) |
| rx_valid | input | 1 | A byte from the master is available |
| rx_data | input | 8 | Received byte |
| rsp_ack_valid | output | 1 | ACK decision for the last received byte is valid |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| tx_req | input | 1 | Engine asks for the next byte to send |
| tx_valid | output | 1 | tx_data answers the last request |
| tx_data | output | 8 | Byte to transmit (0xFF when not transmitting) |
| tx_done | input | 1 | Master's acknowledge bit for the last sent byte |
| tx_nack | input | 1 | With tx_done: 1 = master NACK, 0 = ACK |
| tx_en | output | 1 | Target is in its read data phase |

## Verification
Every result of this block falls on a fixed cycle. An ACK decision appears one cycle after its received byte, and a transmit byte appears one cycle after its request. tx_en falls one cycle after a NACK or STOP. A register write takes effect on the edge that accepts the byte. The bench drives each event as a one-cycle pulse from a falling edge and samples the response at the very next falling edge, when exactly one rising edge has passed. Stored contents and pointer movement are checked only by later reads through the ports, against a model of the register contents kept in the bench.

// File: rtl/smbt_pkg.sv
// Shared types and helpers for the SMBus target responder.
// Assumes byte-wide registers and a block length limit of 32.
package smbt_pkg;

    localparam int unsigned BLK_MAX = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_RDONE,
        ST_SKIP
    } smbt_state_e;

    // Clamp a block length to the protocol maximum
    function automatic logic [7:0] clamp_count(input logic [7:0] c);
        return (c > 8'(BLK_MAX)) ? 8'(BLK_MAX) : c;
    endfunction

    // Reset content of register i: (7*i+3) mod 256
    function automatic logic [7:0] reg_reset(input int unsigned i);
        return 8'((i * 7 + 3) & 255);
    endfunction

endpackage

// File: rtl/smbt_regfile.sv
// Register file of NREG byte registers with one write port and one
// combinational read port. Assumes NREG is a power of two, at most 256.
module smbt_regfile
    import smbt_pkg::*;
#(
    parameter int unsigned NREG = 64,
    localparam int unsigned PW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [7:0]    rd_data
);

    logic [7:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [7:0] q;
        // Hold one register; load reset pattern or write data
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= reg_reset(g);
            else if (wr_en && (wr_idx == PW'(g)))
                q <= wr_data;
        end
        assign regs[g] = q;
    end

    assign rd_data = regs[rd_idx];

endmodule

// File: rtl/smbt_blkcnt.sv
// Remaining-byte counter for a block transfer. Loads a length, counts
// down on each data byte, and reports when nothing is left.
module smbt_blkcnt #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          empty
);

    logic [CW-1:0] left;

    // Track bytes still owed in the current block
    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (load)
            left <= load_val;
        else if (dec && (left != '0))
            left <= left - CW'(1);
    end

    assign empty = (left == '0);

endmodule

// File: rtl/smbt_ctrl.sv
// Transaction sequencer: decodes address and direction, holds the
// register pointer, answers received bytes with ACK/NACK and transmit
// requests with data. Assumes the engine raises at most one event per
// cycle. Priority if not: START, STOP, received byte, request, ack bit.
module smbt_ctrl
    import smbt_pkg::*;
#(
    parameter logic [6:0]   OWN_ADDR   = 7'h2C,
    parameter int unsigned  NREG       = 64,
    parameter logic [NREG-1:0] BLOCK_MASK = '0,
    localparam int unsigned PW         = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          tx_req,
    input  logic          tx_done,
    input  logic          tx_nack,
    output logic          rsp_ack_valid,
    output logic          rsp_ack,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_en,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic [PW-1:0] rd_idx,
    input  logic [7:0]    rd_data,
    output logic          blk_load,
    output logic [7:0]    blk_load_val,
    output logic          blk_dec,
    input  logic          blk_empty
);

    smbt_state_e   st;
    logic [PW-1:0] ptr;
    logic          first_tx;
    logic          blk_mode;
    logic          cnt_phase;

    logic          rx_evt, req_evt, done_evt;
    logic          addr_hit, in_read, wdata_ok, blk_start, tx_out_of_data;
    logic [PW-1:0] cmd_idx;
    logic [7:0]    rx_cnt, rd_cnt;

    // Event qualification by priority
    always_comb begin
        rx_evt   = rx_valid && !bus_start && !bus_stop;
        req_evt  = tx_req && !bus_start && !bus_stop && !rx_valid;
        done_evt = tx_done && !bus_start && !bus_stop && !rx_valid && !tx_req;
    end

    // Decode of incoming bytes and of the read path
    always_comb begin
        addr_hit       = (rx_data[7:1] == OWN_ADDR);
        cmd_idx        = rx_data[PW-1:0];
        rx_cnt         = clamp_count(rx_data);
        rd_cnt         = clamp_count(rd_data);
        in_read        = (st == ST_RDATA);
        wdata_ok       = (st == ST_WDATA) && (cnt_phase || !(blk_mode && blk_empty));
        blk_start      = req_evt && in_read && first_tx && BLOCK_MASK[ptr];
        tx_out_of_data = !first_tx && blk_mode && blk_empty;
    end

    // Register-file and block-counter controls
    always_comb begin
        wr_en        = rx_evt && wdata_ok;
        wr_idx       = ptr;
        wr_data      = cnt_phase ? rx_cnt : rx_data;
        rd_idx       = ptr;
        blk_load     = (rx_evt && (st == ST_WDATA) && cnt_phase) || blk_start;
        blk_load_val = blk_start ? rd_cnt : rx_cnt;
        blk_dec      = (rx_evt && wdata_ok && !cnt_phase && blk_mode)
                     || (req_evt && in_read && !first_tx && blk_mode && !blk_empty);
        tx_en        = in_read;
    end

    // Transaction state, pointer and registered responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_IDLE;
            ptr           <= '0;
            first_tx      <= 1'b0;
            blk_mode      <= 1'b0;
            cnt_phase     <= 1'b0;
            rsp_ack_valid <= 1'b0;
            rsp_ack       <= 1'b0;
            tx_valid      <= 1'b0;
            tx_data       <= 8'hFF;
        end else begin
            rsp_ack_valid <= 1'b0;
            tx_valid      <= 1'b0;
            if (bus_start) begin
                st        <= ST_ADDR;
                blk_mode  <= 1'b0;
                cnt_phase <= 1'b0;
            end else if (bus_stop) begin
                st        <= ST_IDLE;
                blk_mode  <= 1'b0;
                cnt_phase <= 1'b0;
            end else if (rx_evt) begin
                rsp_ack_valid <= 1'b1;
                unique case (st)
                    ST_ADDR: begin
                        rsp_ack  <= addr_hit;
                        first_tx <= 1'b1;
                        if (!addr_hit)
                            st <= ST_SKIP;
                        else if (rx_data[0])
                            st <= ST_RDATA;
                        else
                            st <= ST_CMD;
                    end
                    ST_CMD: begin
                        rsp_ack   <= 1'b1;
                        ptr       <= cmd_idx;
                        cnt_phase <= BLOCK_MASK[cmd_idx];
                        blk_mode  <= BLOCK_MASK[cmd_idx];
                        st        <= ST_WDATA;
                    end
                    ST_WDATA: begin
                        rsp_ack <= wdata_ok;
                        if (wdata_ok) begin
                            ptr       <= ptr + PW'(1);
                            cnt_phase <= 1'b0;
                        end
                    end
                    default: rsp_ack <= 1'b0;
                endcase
            end else if (req_evt) begin
                tx_valid <= 1'b1;
                if (!in_read) begin
                    tx_data <= 8'hFF;
                end else if (first_tx) begin
                    first_tx <= 1'b0;
                    blk_mode <= BLOCK_MASK[ptr];
                    tx_data  <= BLOCK_MASK[ptr] ? rd_cnt : rd_data;
                    ptr      <= ptr + PW'(1);
                end else if (tx_out_of_data) begin
                    tx_data <= 8'hFF;
                end else begin
                    tx_data <= rd_data;
                    ptr     <= ptr + PW'(1);
                end
            end else if (done_evt) begin
                if (in_read && tx_nack)
                    st <= ST_RDONE;
            end
        end
    end

endmodule

// File: rtl/smbus_target_resp.sv
// SMBus target register responder, top level. Joins the transaction
// sequencer, the register file and the block-length counter. Assumes a
// byte engine below that delivers single-cycle bus events.
module smbus_target_resp
    import smbt_pkg::*;
#(
    parameter logic [6:0]      OWN_ADDR   = 7'h2C,
    parameter int unsigned     NREG       = 64,
    parameter logic [NREG-1:0] BLOCK_MASK = 64'h0001_0001_0000_0000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rsp_ack_valid,
    output logic       rsp_ack,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_done,
    input  logic       tx_nack,
    output logic       tx_en
);

    localparam int unsigned PW = $clog2(NREG);

    logic          wr_en;
    logic [PW-1:0] wr_idx, rd_idx;
    logic [7:0]    wr_data, rd_data;
    logic          blk_load, blk_dec, blk_empty;
    logic [7:0]    blk_load_val;

    smbt_ctrl #(
        .OWN_ADDR  (OWN_ADDR),
        .NREG      (NREG),
        .BLOCK_MASK(BLOCK_MASK)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_start    (bus_start),
        .bus_stop     (bus_stop),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .tx_req       (tx_req),
        .tx_done      (tx_done),
        .tx_nack      (tx_nack),
        .rsp_ack_valid(rsp_ack_valid),
        .rsp_ack      (rsp_ack),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_en        (tx_en),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .rd_idx       (rd_idx),
        .rd_data      (rd_data),
        .blk_load     (blk_load),
        .blk_load_val (blk_load_val),
        .blk_dec      (blk_dec),
        .blk_empty    (blk_empty)
    );

    smbt_regfile #(.NREG(NREG)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .rd_idx (rd_idx),
        .rd_data(rd_data)
    );

    smbt_blkcnt #(.CW(8)) u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (blk_load),
        .load_val(blk_load_val),
        .dec     (blk_dec),
        .empty   (blk_empty)
    );

endmodule

// File: rtl/smbt_checker.sv
// Port-level protocol checks for the SMBus target responder, bound to
// every instance of the top module.
module smbt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_start,
    input logic       bus_stop,
    input logic       rx_valid,
    input logic       rsp_ack_valid,
    input logic       rsp_ack,
    input logic       tx_req,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_done,
    input logic       tx_nack,
    input logic       tx_en
);

    AST_ACK_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rsp_ack_valid); // R11

    AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack_valid |-> $past(rx_valid)); // R11

    AST_TX_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid); // R11

    AST_NACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_nack && !bus_start && !rx_valid && !tx_req) |=> !tx_en); // R5

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !bus_start) |=> !tx_en); // R8

    AST_READ_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (rsp_ack_valid && rsp_ack)); // R1

    AST_IDLE_SENDS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !$past(tx_en)) |-> (tx_data == 8'hFF)); // R5

endmodule

bind smbus_target_resp smbt_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_start    (bus_start),
    .bus_stop     (bus_stop),
    .rx_valid     (rx_valid),
    .rsp_ack_valid(rsp_ack_valid),
    .rsp_ack      (rsp_ack),
    .tx_req       (tx_req),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_done      (tx_done),
    .tx_nack      (tx_nack),
    .tx_en        (tx_en)
);

// File: tb/smbus_target_resp_test.sv
// Self-checking bench: sweeps addresses and registers, exercises word,
// wrap, block and release behaviour against a bench-side register model.
module smbus_target_resp_test;

    localparam logic [6:0] OWN = 7'h2C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_req = 1'b0, tx_done = 1'b0, tx_nack = 1'b0;
    logic       rsp_ack_valid, rsp_ack, tx_valid, tx_en;
    logic [7:0] tx_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [64];

    always #4 clk = ~clk;

    smbus_target_resp uut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_data(rx_data), .rsp_ack_valid(rsp_ack_valid),
        .rsp_ack(rsp_ack), .tx_req(tx_req), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_done(tx_done), .tx_nack(tx_nack), .tx_en(tx_en)
    );

    function automatic bit is_blk(int r);
        return (r == 32) || (r == 48);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic start();
        @(negedge clk) bus_start = 1'b1;
        @(negedge clk) bus_start = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk) bus_stop = 1'b1;
        @(negedge clk) bus_stop = 1'b0;
    endtask

    // Send one byte and check the ACK decision one cycle later
    task automatic put(logic [7:0] b, bit exp_ack, string req);
        @(negedge clk) begin rx_valid = 1'b1; rx_data = b; end
        @(negedge clk) rx_valid = 1'b0;
        chk(rsp_ack_valid === 1'b1, "R11 ack strobe", int'(rsp_ack_valid), 1);
        chk(rsp_ack === exp_ack, req, int'(rsp_ack), int'(exp_ack));
    endtask

    // Request one byte and check it one cycle later
    task automatic get(logic [7:0] exp, string req);
        @(negedge clk) tx_req = 1'b1;
        @(negedge clk) tx_req = 1'b0;
        chk(tx_valid === 1'b1, "R11 tx strobe", int'(tx_valid), 1);
        chk(tx_data === exp, req, int'(tx_data), int'(exp));
    endtask

    task automatic fin(bit nack);
        @(negedge clk) begin tx_done = 1'b1; tx_nack = nack; end
        @(negedge clk) begin tx_done = 1'b0; tx_nack = 1'b0; end
    endtask

    task automatic sel(int r);
        start();
        put({OWN, 1'b0}, 1'b1, "R1 write address");
        put(8'(r), 1'b1, "R2 command");
    endtask

    task automatic rd_open();
        start();
        put({OWN, 1'b1}, 1'b1, "R1 read address");
    endtask

    // Select r, repeated START, read one byte, NACK it
    task automatic read_one(int r, string req);
        sel(r);
        rd_open();
        get(mem[r], req);
        fin(1'b1);
        stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'((i * 7 + 3) & 255);
        repeat (3) @(negedge clk);
        chk(rsp_ack_valid === 1'b0, "R10 ack idle", int'(rsp_ack_valid), 0);
        chk(tx_valid === 1'b0, "R10 tx idle", int'(tx_valid), 0);
        chk(tx_en === 1'b0, "R10 tx_en idle", int'(tx_en), 0);
        rst_n = 1'b1;

        // R10 pointer 0, then R5 release after NACK
        rd_open();
        get(mem[0], "R10 pointer at 0");
        fin(1'b1);
        chk(tx_en === 1'b0, "R5 tx_en after NACK", int'(tx_en), 0);
        get(8'hFF, "R5 idle byte after NACK");
        stop();

        // R1 / R9 address sweep
        for (int a = 0; a < 128; a++) begin
            for (int d = 0; d < 2; d++) begin
                start();
                put({7'(a), 1'(d)}, (a == OWN), "R1 address match");
                chk(tx_en === ((a == OWN) && (d == 1)), "R1 read phase",
                    int'(tx_en), int'((a == OWN) && (d == 1)));
                if (a != OWN) put(8'h00, 1'b0, "R9 ignored byte");
                stop();
            end
        end

        // R3 / R10 reset contents via command + repeated START
        for (int r = 0; r < 64; r++)
            if (!is_blk(r)) read_one(r, "R3 R10 reset value");

        // R2 byte writes, read back
        for (int r = 0; r < 64; r++) begin
            if (!is_blk(r)) begin
                sel(r);
                put(8'((r * 13 + 8'h41) & 255), 1'b1, "R2 data ack");
                stop();
                mem[r] = 8'((r * 13 + 8'h41) & 255);
            end
        end
        for (int r = 0; r < 64; r++)
            if (!is_blk(r)) read_one(r, "R2 written value");

        // R4 word low/high and wrap
        sel(10); put(8'h34, 1'b1, "R4 low"); put(8'h12, 1'b1, "R4 high"); stop();
        mem[10] = 8'h34; mem[11] = 8'h12;
        sel(10); rd_open();
        get(8'h34, "R4 word low"); fin(1'b0); get(8'h12, "R4 word high"); fin(1'b1); stop();
        sel(63); put(8'hC3, 1'b1, "R4 wrap w0"); put(8'h3C, 1'b1, "R4 wrap w1"); stop();
        mem[63] = 8'hC3; mem[0] = 8'h3C;
        sel(63); rd_open();
        get(8'hC3, "R4 wrap r0"); fin(1'b0); get(8'h3C, "R4 wrap r1"); fin(1'b1); stop();

        // R3 receive byte, R4 increment on read, R5 no advance after NACK
        sel(20); stop();
        rd_open(); get(mem[20], "R3 receive byte"); fin(1'b0);
        get(mem[21], "R4 read increment"); fin(1'b1);
        get(8'hFF, "R5 after NACK"); stop();
        rd_open(); get(mem[22], "R5 pointer held"); fin(1'b1); stop();
        start(); put({OWN, 1'b0}, 1'b1, "R1"); put(8'h07, 1'b1, "R2 send byte"); stop();
        rd_open(); get(mem[7], "R3 send byte selects"); fin(1'b1); stop();

        // R9 foreign address writes nothing
        start(); put({7'h2D, 1'b0}, 1'b0, "R9 foreign address");
        put(8'h05, 1'b0, "R9 cmd ignored"); put(8'h77, 1'b0, "R9 data ignored"); stop();
        read_one(5, "R9 register untouched");

        // R8 nothing after STOP
        sel(9); stop();
        put(8'h99, 1'b0, "R8 byte after STOP");
        get(8'hFF, "R8 request after STOP");
        chk(tx_en === 1'b0, "R8 tx_en after STOP", int'(tx_en), 0);
        rd_open(); get(mem[9], "R8 register untouched"); fin(1'b1); stop();

        // R7 block write count 5, R6 block read
        sel(32); put(8'd5, 1'b1, "R7 count");
        for (int i = 0; i < 5; i++) begin
            put(8'(8'h90 + i), 1'b1, "R7 block data");
            mem[33 + i] = 8'(8'h90 + i);
        end
        put(8'hEE, 1'b0, "R7 excess NACK"); stop();
        mem[32] = 8'd5;
        sel(32); rd_open(); get(8'd5, "R6 count");
        for (int i = 0; i < 5; i++) begin fin(1'b0); get(mem[33 + i], "R6 block byte"); end
        fin(1'b0); get(8'hFF, "R6 past count"); fin(1'b1); stop();
        read_one(38, "R7 excess not stored");

        // R7 count clamp to 32, R6 read back
        sel(48); put(8'd40, 1'b1, "R7 count 40");
        for (int i = 0; i < 32; i++) begin
            put(8'(i * 3 + 1), 1'b1, "R7 block data");
            mem[(49 + i) & 63] = 8'(i * 3 + 1);
        end
        put(8'h55, 1'b0, "R7 33rd NACK"); stop();
        mem[48] = 8'd32;
        sel(48); rd_open(); get(8'd32, "R6 R7 clamped count");
        for (int i = 0; i < 32; i++) begin fin(1'b0); get(mem[(49 + i) & 63], "R6 block byte"); end
        fin(1'b0); get(8'hFF, "R6 past count"); fin(1'b1); stop();

        // Final readback of all plain registers
        for (int r = 0; r < 64; r++)
            if (!is_blk(r)) read_one(r, "R2 final contents");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule